// File: doc/BRIEF.md
# Cache Read-Path ECC Checker with Silent Line Refetch

This block is the read path of a small direct-mapped cache. Every stored data word carries seven check bits of a single-error-correct, double-error-detect code. A read that hits has its word checked. If one bit is wrong, the word is repaired in the datapath and the repaired value is returned. If two bits are wrong, the line is dropped and refilled from backing memory, and the read is served from the fresh copy. A read that misses refills the line without any check. The processor is never told that an error happened. If the dropped line held modified data, that data is lost and the read returns the older memory copy. The only record of this is a sticky debug flag that the processor cannot see.

The CPU side has a request channel and a response channel, each with valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Only one read can be in flight. `req_ready` stays low from the acceptance of a read until its response has been taken. The response holds `rsp_valid` and `rsp_data` steady until `rsp_ready` is seen high. Writes update a word only when they hit, and they produce no response.

The refill side issues one line request. The request holds until `mem_req_ready` is high. The memory then returns one word per cycle in which `mem_rsp_valid` is high, and the block accepts every such beat at once. Gaps between beats are allowed.

Top module: `ecc_refetch_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `mem_req_valid` and `dirty_drop_seen` are 0, and every line is invalid, so the first read to any address refills.
- R2: Each stored word is a 39-bit codeword. Bits 38:7 hold data bits 31:0. Bits 5:0 are Hamming check bits over data placed at the non-power-of-two positions 3..38. Bit 6 makes the parity of all 39 bits even. Check bits are generated on every refill beat and on every write hit.
- R3: A read that hits a word with no error returns the stored word with `rsp_valid` rising one cycle after the accepting edge, and issues no memory request.
- R4: With `ecc_en` high, a hit on a word with any single flipped bit among the 39 returns the corrected data and issues no memory request. Nothing visible to the requester differs from a clean hit.
- R5: With `ecc_en` high, a hit on a word with two flipped bits drops the line. The block issues one request for that line (`mem_req_addr` = read address with the word offset removed) and returns the refilled memory word. Writes made earlier to that line are lost.
- R6: `dirty_drop_seen` becomes 1 when a line is dropped for a double error while `line_dirty` is high, and then stays 1 until reset. A drop with `line_dirty` low leaves it unchanged.
- R7: A read miss refills the line and returns the memory word. A write miss changes no line and issues no memory request.
- R8: With `ecc_en` low, a hit returns stored data bits 38:7 unchanged, even when they are corrupted, and never refetches.
- R9: `req_ready` is low while a response is pending or a refill is in progress. The response stays valid and stable until `rsp_ready` is high. `mem_req_valid` and `mem_req_addr` stay stable until `mem_req_ready` is high.
- R10: A refill takes exactly WORDS beats. Beats are written at increasing word offsets starting at 0, whatever the gaps between them.
- R11: A write hit replaces the word with the encoded write data XOR `req_flip` (the fault-injection mask in the R2 layout). It produces no response and leaves `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Enables checking and correction on hits |
| line_dirty | input | 1 | High when the line being looked up holds modified data |
| req_valid | input | 1 | CPU request valid |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address: tag, index, offset |
| req_wdata | input | 32 | Write data |
| req_flip | input | 39 | Codeword bits to invert on a write hit |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 32 | Read data |
| mem_req_valid | output | 1 | Line refill request valid |
| mem_req_ready | input | 1 | Memory accepts the refill request |
| mem_req_addr | output | AW-log2(WORDS) | Line address to refill |
| mem_rsp_valid | input | 1 | Refill beat valid |
| mem_rsp_data | input | 32 | Refill beat data |
| dirty_drop_seen | output | 1 | Sticky debug flag: dirty data was discarded |

## Verification
The bench injects single flips into a data bit, a Hamming check bit, the overall parity bit and the top data bit. A decoder that mapped a syndrome to the wrong bit would return corrupted data. One that called a parity-bit flip uncorrectable would issue a needless refetch that the bench counts. Double flips are injected on clean and dirty lines. The bench then reads a second word of the dropped line to prove the earlier write was discarded, and watches the sticky flag stay set. With checking turned off, it expects the raw corrupted bits and no refetch, which catches a design that still corrects or refills. Write misses to a conflicting tag, refill beats with gaps, and a held-off response complete the set; these catch wrong allocation, beat miscounting and a response that changes before it is taken.

// File: rtl/ecc_refetch_pkg.sv
package ecc_refetch_pkg;

  localparam int DW = 32;       // data bits per word
  localparam int PW = 7;        // check bits per word
  localparam int CW = DW + PW;  // stored codeword width
  localparam int HP = DW + 6;   // highest Hamming position

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_FILL,
    ST_RESP
  } ctl_state_e;

  typedef enum logic [1:0] {
    CK_CLEAN,
    CK_FIXED,
    CK_FATAL
  } ck_kind_e;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  // place data bits at the non-power-of-two Hamming positions
  function automatic logic [HP:1] spread(input logic [DW-1:0] d);
    logic [HP:1] v;
    int k;
    v = '0;
    k = 0;
    for (int p = 1; p <= HP; p++) begin
      if (!is_pow2(p)) begin
        v[p] = d[k];
        k++;
      end
    end
    return v;
  endfunction

  // inverse of spread
  function automatic logic [DW-1:0] gather(input logic [HP:1] v);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= HP; p++) begin
      if (!is_pow2(p)) begin
        d[k] = v[p];
        k++;
      end
    end
    return d;
  endfunction

  // XOR of the positions of all set bits
  function automatic logic [5:0] pos_xor(input logic [HP:1] v);
    logic [5:0] s;
    s = '0;
    for (int p = 1; p <= HP; p++) begin
      if (v[p]) s = s ^ 6'(p);
    end
    return s;
  endfunction

endpackage

// File: rtl/secded_gen.sv
module secded_gen
  import ecc_refetch_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [PW-1:0] check_o
);

  logic [5:0] ham;

  always_comb begin
    ham     = pos_xor(spread(data_i));
    check_o = {(^data_i) ^ (^ham), ham};
  end

endmodule

// File: rtl/secded_chk.sv
module secded_chk
  import ecc_refetch_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output ck_kind_e      kind_o
);

  logic [DW-1:0] raw;
  logic [5:0]    syn;
  logic          par_bad;
  logic [HP:1]   pos_hot;
  logic [DW-1:0] fix_mask;

  assign raw     = cw_i[CW-1:PW];
  assign syn     = pos_xor(spread(raw)) ^ cw_i[5:0];
  assign par_bad = ^cw_i;

  always_comb begin
    for (int p = 1; p <= HP; p++) pos_hot[p] = (syn == 6'(p));
  end

  always_comb begin
    fix_mask = '0;
    kind_o   = CK_CLEAN;
    if (par_bad) begin
      if (is_pow2(int'(syn))) begin
        kind_o = CK_FIXED;             // a check bit or the parity bit flipped
      end else if (int'(syn) <= HP) begin
        kind_o   = CK_FIXED;
        fix_mask = gather(pos_hot);
      end else begin
        kind_o = CK_FATAL;             // odd weight, syndrome off the code
      end
    end else if (syn != 6'd0) begin
      kind_o = CK_FATAL;               // even weight, non-zero syndrome
    end
  end

  assign data_o = raw ^ fix_mask;

endmodule

// File: rtl/line_store.sv
module line_store
  import ecc_refetch_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int TAGW  = 7,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [OFFW-1:0] lk_off,
  output logic            lk_valid,
  output logic [TAGW-1:0] lk_tag,
  output logic [CW-1:0]   lk_cw,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [OFFW-1:0] wr_off,
  input  logic [CW-1:0]   wr_cw,
  input  logic            set_en,
  input  logic [TAGW-1:0] set_tag,
  input  logic            clr_en
);

  logic [LINES-1:0]             vld_vec;
  logic [TAGW-1:0]              tag_arr  [LINES];
  logic [WORDS-1:0][CW-1:0]     line_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic                     v_q;
    logic [TAGW-1:0]          t_q;
    logic [WORDS-1:0][CW-1:0] w_q;
    logic                     sel;

    assign sel = (wr_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (sel && set_en) begin
        v_q <= 1'b1;
        t_q <= set_tag;
      end else if (sel && clr_en) begin
        v_q <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (sel && wr_en) w_q[wr_off] <= wr_cw;
    end

    assign vld_vec[g]  = v_q;
    assign tag_arr[g]  = t_q;
    assign line_arr[g] = w_q;
  end

  assign lk_valid = vld_vec[lk_idx];
  assign lk_tag   = tag_arr[lk_idx];
  assign lk_cw    = line_arr[lk_idx][lk_off];

endmodule

// File: rtl/ecc_refetch_cache.sv
module ecc_refetch_cache
  import ecc_refetch_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int AW    = 12,
  localparam int OFFW = $clog2(WORDS),
  localparam int IDXW = $clog2(LINES),
  localparam int TAGW = AW - OFFW - IDXW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ecc_en,
  input  logic             line_dirty,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [38:0]      req_flip,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [31:0]      rsp_data,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-OFFW-1:0] mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_data,
  output logic             dirty_drop_seen
);

  ctl_state_e      st;
  logic [AW-1:0]   addr_q;
  logic [OFFW-1:0] beat_q;
  logic [DW-1:0]   rsp_q;
  logic            drop_q;

  logic [AW-1:0]   lk_addr;
  logic [OFFW-1:0] lk_off;
  logic [IDXW-1:0] lk_idx;
  logic [TAGW-1:0] lk_tagf;
  logic            lk_valid;
  logic [TAGW-1:0] lk_tag;
  logic [CW-1:0]   lk_cw;
  logic            hit;
  logic [DW-1:0]   fixed_data;
  ck_kind_e        kind;
  logic            serve_ok;

  logic [DW-1:0]   enc_src;
  logic [PW-1:0]   enc_chk;
  logic [CW-1:0]   wr_cw;
  logic            wr_en;
  logic [OFFW-1:0] wr_off;
  logic            fill_beat;
  logic            last_beat;
  logic            set_en;
  logic            clr_en;

  // one lookup port: the incoming address while idle, the held one otherwise
  assign lk_addr = (st == ST_IDLE) ? req_addr : addr_q;
  assign lk_off  = lk_addr[OFFW-1:0];
  assign lk_idx  = lk_addr[OFFW +: IDXW];
  assign lk_tagf = lk_addr[AW-1 -: TAGW];
  assign hit     = lk_valid && (lk_tag == lk_tagf);

  secded_chk u_chk_dec (
    .cw_i   (lk_cw),
    .data_o (fixed_data),
    .kind_o (kind)
  );

  assign serve_ok = hit && (!ecc_en || (kind != CK_FATAL));

  // one encoder shared between write hits and refill beats
  assign enc_src = (st == ST_FILL) ? mem_rsp_data : req_wdata;

  secded_gen u_enc (
    .data_i  (enc_src),
    .check_o (enc_chk)
  );

  assign wr_cw     = {enc_src, enc_chk} ^ ((st == ST_IDLE) ? req_flip : '0);
  assign fill_beat = (st == ST_FILL) && mem_rsp_valid;
  assign last_beat = fill_beat && (beat_q == OFFW'(WORDS - 1));
  assign wr_en     = fill_beat ||
                     ((st == ST_IDLE) && req_valid && req_write && hit);
  assign wr_off    = (st == ST_FILL) ? beat_q : lk_off;
  assign set_en    = last_beat;
  assign clr_en    = (st == ST_LOOK) && !serve_ok;

  line_store #(
    .LINES (LINES),
    .WORDS (WORDS),
    .TAGW  (TAGW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (lk_idx),
    .lk_off   (lk_off),
    .lk_valid (lk_valid),
    .lk_tag   (lk_tag),
    .lk_cw    (lk_cw),
    .wr_en    (wr_en),
    .wr_idx   (lk_idx),
    .wr_off   (wr_off),
    .wr_cw    (wr_cw),
    .set_en   (set_en),
    .set_tag  (lk_tagf),
    .clr_en   (clr_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      beat_q <= '0;
      rsp_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid && !req_write) begin
            addr_q <= req_addr;
            st     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (serve_ok) begin
            rsp_q <= ecc_en ? fixed_data : lk_cw[CW-1:PW];
            st    <= ST_RESP;
          end else begin
            if (hit && line_dirty) drop_q <= 1'b1;
            st <= ST_MREQ;
          end
        end
        ST_MREQ: begin
          beat_q <= '0;
          if (mem_req_ready) st <= ST_FILL;
        end
        ST_FILL: begin
          if (mem_rsp_valid) begin
            beat_q <= beat_q + 1'b1;
            if (last_beat) st <= ST_LOOK;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready       = (st == ST_IDLE);
  assign rsp_valid       = (st == ST_RESP);
  assign rsp_data        = rsp_q;
  assign mem_req_valid   = (st == ST_MREQ);
  assign mem_req_addr    = addr_q[AW-1:OFFW];
  assign dirty_drop_seen = drop_q;

endmodule

// File: rtl/ecc_refetch_cache_chk.sv
module ecc_refetch_cache_chk #(
  parameter int MAW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic           rsp_valid,
  input logic           rsp_ready,
  input logic [31:0]    rsp_data,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [MAW-1:0] mem_req_addr,
  input logic           dirty_drop_seen
);

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);  // R9

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));  // R9

  AST_MREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R9

  AST_STALL_ON_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);  // R5

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_drop_seen |=> dirty_drop_seen);  // R6

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write |=> !rsp_valid && req_ready);  // R11

endmodule

bind ecc_refetch_cache ecc_refetch_cache_chk #(
  .MAW (AW - OFFW)
) u_props (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_write       (req_write),
  .rsp_valid       (rsp_valid),
  .rsp_ready       (rsp_ready),
  .rsp_data        (rsp_data),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .dirty_drop_seen (dirty_drop_seen)
);

// File: tb/sim_ecc_refetch_cache.sv
`timescale 1ns/1ps
module sim_ecc_refetch_cache;

  localparam int LINES = 8;
  localparam int WORDS = 4;
  localparam int AW    = 12;
  localparam int OFFW  = $clog2(WORDS);
  localparam int IDXW  = $clog2(LINES);
  localparam int TAGW  = AW - OFFW - IDXW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1;
  logic line_dirty = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [38:0] req_flip = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic mem_req_valid;
  logic mem_req_ready;
  logic [AW-OFFW-1:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic dirty_drop_seen;

  int checks = 0;
  int fails = 0;
  int n_fetch = 0;
  bit done = 1'b0;
  logic [AW-OFFW-1:0] fetch_addr = '0;

  always #2.5 clk = ~clk;

  ecc_refetch_cache #(.LINES(LINES), .WORDS(WORDS), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .line_dirty(line_dirty),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_flip(req_flip),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .dirty_drop_seen(dirty_drop_seen)
  );

  // ---------------- reference model ----------------
  logic            mv [LINES];
  logic [TAGW-1:0] mt [LINES];
  logic [31:0]     md [LINES][WORDS];
  logic [38:0]     mf [LINES][WORDS];
  logic            mlost = 1'b0;

  function automatic logic [31:0] memw(input logic [AW-1:0] a);
    return 32'h5A00_0000 ^ (32'(a) * 32'h0001_0F31);
  endfunction

  function automatic logic [38:0] dbit(input int k);
    return 39'(1) << (7 + k);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_fill(input int i, input logic [TAGW-1:0] t);
    for (int w = 0; w < WORDS; w++) begin
      md[i][w] = memw({t, IDXW'(i), OFFW'(w)});
      mf[i][w] = '0;
    end
    mv[i] = 1'b1;
    mt[i] = t;
  endtask

  task automatic model_read(input logic [AW-1:0] a, output logic [31:0] exp, output bit fetch);
    int i, o;
    logic [TAGW-1:0] t;
    o = int'(a[OFFW-1:0]);
    i = int'(a[OFFW +: IDXW]);
    t = a[AW-1 -: TAGW];
    fetch = 1'b0;
    if (!(mv[i] && mt[i] == t)) begin
      model_fill(i, t);
      fetch = 1'b1;
      exp = md[i][o];
    end else if (ecc_en && $countones(mf[i][o]) >= 2) begin
      if (line_dirty) mlost = 1'b1;
      model_fill(i, t);
      fetch = 1'b1;
      exp = md[i][o];
    end else if (ecc_en) begin
      exp = md[i][o];
    end else begin
      exp = md[i][o] ^ mf[i][o][38:7];
    end
  endtask

  // ---------------- memory responder ----------------
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (n_fetch % 2) @(negedge clk);
        mem_req_ready = 1'b1;
        fetch_addr = mem_req_addr;
        n_fetch++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int b = 0; b < WORDS; b++) begin
          repeat ((n_fetch + b) % 3) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memw({fetch_addr, OFFW'(b)});
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  // per-cycle handshake comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(!(rsp_valid && req_ready), "R9 ready while response pending", 64'(req_ready), 64'd0);
      check(!(mem_req_valid && req_ready), "R9 ready during refill", 64'(req_ready), 64'd0);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [38:0] fl, input string req);
    int i;
    int f0;
    f0 = n_fetch;
    i = int'(a[OFFW +: IDXW]);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_flip = fl;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_flip = '0;
    if (mv[i] && mt[i] == a[AW-1 -: TAGW]) begin
      md[i][int'(a[OFFW-1:0])] = d;
      mf[i][int'(a[OFFW-1:0])] = fl;
    end
    check(!rsp_valid && req_ready, {req, " write gives no response"}, 64'(rsp_valid), 64'd0);
    check(!mem_req_valid && n_fetch == f0, {req, " write issues no fetch"}, 64'(n_fetch - f0), 64'd0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input int hold, input string req);
    logic [31:0] exp;
    logic [31:0] first;
    bit fetch;
    int f0, lat;
    f0 = n_fetch;
    model_read(a, exp, fetch);
    rsp_ready = (hold == 0);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    if (hold > 0) begin
      first = rsp_data;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        check(rsp_valid && rsp_data == first, {req, " R9 response held"}, 64'(rsp_data), 64'(first));
      end
      rsp_ready = 1'b1;
    end
    check(rsp_data == exp, {req, " data"}, 64'(rsp_data), 64'(exp));
    check((n_fetch - f0) == int'(fetch), {req, " fetch count"}, 64'(n_fetch - f0), 64'(fetch));
    if (fetch)
      check(fetch_addr == a[AW-1:OFFW], {req, " R5 line address"}, 64'(fetch_addr), 64'(a[AW-1:OFFW]));
    else
      check(lat == 1, {req, " R3 hit latency"}, 64'(lat), 64'd1);
    @(negedge clk);
    check(!rsp_valid && req_ready, {req, " R9 response retired"}, 64'(rsp_valid), 64'd0);
    check(dirty_drop_seen == mlost, {req, " R6 drop flag"}, 64'(dirty_drop_seen), 64'(mlost));
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [AW-1:0] A = 12'h014;  // index 5, tag 0
  localparam logic [AW-1:0] B = 12'h094;  // index 5, tag 4
  localparam logic [AW-1:0] C = 12'h3FC;  // index 7

  initial begin
    for (int i = 0; i < LINES; i++) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready, "R1 req_ready", 64'(req_ready), 64'd1);
    check(!rsp_valid && !mem_req_valid, "R1 idle outputs", 64'({rsp_valid, mem_req_valid}), 64'd0);
    check(!dirty_drop_seen, "R1 drop flag", 64'(dirty_drop_seen), 64'd0);

    do_read(A, 0, "R1 R7 R10 first read misses");
    do_read(A + 1, 0, "R3 clean hit");
    do_write(A + 2, 32'hDEAD_BEEF, '0, "R11");
    do_read(A + 2, 0, "R2 R11 written word");
    do_write(A + 2, 32'h1234_5678, dbit(13), "R4");
    do_read(A + 2, 0, "R4 data bit flip");
    do_write(A + 2, 32'h0BAD_CAFE, 39'(1) << 3, "R4");
    do_read(A + 2, 0, "R4 check bit flip");
    do_write(A + 2, 32'h7777_1111, 39'(1) << 6, "R4");
    do_read(A + 2, 0, "R4 parity bit flip");
    do_write(A + 2, 32'hF00D_0001, dbit(31), "R4");
    do_read(A + 2, 0, "R4 top data bit flip");

    line_dirty = 1'b0;
    do_write(A + 3, 32'hCAFE_F00D, dbit(2) | dbit(23), "R5");
    do_read(A + 3, 0, "R5 double error clean line");
    do_read(A + 2, 0, "R5 earlier write discarded");

    line_dirty = 1'b1;
    do_write(A, 32'h55AA_55AA, dbit(0) | (39'(1) << 1), "R6");
    do_read(A, 0, "R6 double error dirty line");
    line_dirty = 1'b0;
    do_read(A, 0, "R6 flag stays set");

    ecc_en = 1'b0;
    do_write(A + 1, 32'h0F0F_0F0F, dbit(0) | dbit(31), "R8");
    do_read(A + 1, 0, "R8 raw corrupted data");
    do_write(A + 2, 32'h2468_ACE0, (39'(1) << 2) | (39'(1) << 3), "R8");
    do_read(A + 2, 0, "R8 check bits ignored");
    ecc_en = 1'b1;
    do_read(A + 1, 0, "R5 double error after re-enable");

    do_write(B, 32'h1111_1111, '0, "R7 write miss");
    do_read(A, 0, "R7 line kept after write miss");
    do_read(B, 0, "R7 read miss conflicting tag");
    do_read(A, 0, "R7 evicted line refills");

    do_read(C, 3, "R9 R10 held response on miss");
    do_read(C + 3, 2, "R9 held response on hit");
    do_read(C - 4, 0, "R10 another line");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule